// File: doc/BRIEF.md
# Leveled Interrupt Acceptance and Dispatch Controller

This block decides when a CPU takes an interrupt and, once one is taken, drives the steps the CPU must perform. Each of several sources presents a request flag, a local enable and a 3-bit priority level. The block holds the CPU's level mask, global interrupt enable and stack-select flag. It looks for a qualifying source only at an instruction boundary or after one step of a repeated string operation. A source qualifies when the global enable, its request and its enable are all set and its level is strictly below the mask. The lowest level wins. On a tie, the lowest source index wins.

A per-source automatic-service bit decides what happens to an accepted request. If the bit is set, the request goes to an external transfer engine for a programmed number of transfers. The source can also end the run early. When the run ends, the block clears that bit and the same request enters the normal path. In the normal path, the block asks the CPU to save its dedicated registers. It then raises the mask to the accepted level, selects the system stack and tells the CPU to load the vector. A software interrupt skips all gating and clears the global enable. A return-from-interrupt reloads the mask and flags from values that the CPU has restored from its stack.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the mask to 7, clears the global enable and the stack flag, clears every automatic-service bit, and leaves no strobe and no busy indication.
- R2: A source is accepted only when the global enable, its request and its enable are all 1 and its level is strictly less than the mask. A level equal to the mask, and level 7, are never accepted.
- R3: Acceptance is evaluated only in a cycle where `insn_bound` or `str_step` is high. Qualifying requests in other cycles cause nothing.
- R4: The winner is the qualifying source with the numerically lowest level, with ties going to the lowest index. `vec_num` equals `VEC_BASE` plus the winner's index in the single cycle that `accept` is high, and is 0 otherwise.
- R5: `accept` and `save_req` rise in the cycle after the deciding edge. `save_req` stays high until the cycle in which `save_done` is seen. `mask_upd` then holds for one cycle, followed by `vec_load` for one cycle, and the block is then idle. No new acceptance happens while the sequence runs.
- R6: After a normal hardware acceptance, the mask equals the accepted level and the stack flag is 1 from the `vec_load` cycle onward. The global enable is unchanged.
- R7: When the winner's automatic-service bit is set, `xfer_req` rises in place of `accept`, and `xfer_src` gives the source. A 16-bit count loaded from `xfer_count` falls by one per `xfer_done`. One cycle after it reaches 0, `xfer_req` drops, the source's automatic-service bit is cleared, and `accept` rises for that source. A count of 0 ends the run one cycle after it starts.
- R8: An `xfer_term` pulse during a transfer run ends it at that edge in the same way as R7.
- R9: While idle, `sw_int` is taken whatever the enable and mask are. It clears the global enable at once and raises `save_req` without `accept`. The block returns to idle after `save_done`, with the mask unchanged.
- R10: A `reti` pulse loads the mask, global enable and stack flag from `rest_ilm`, `rest_gie` and `rest_stk`.
- R11: A `cpu_wr` pulse loads the mask, global enable and stack flag from `cpu_ilm`, `cpu_gie` and `cpu_stk`. An `auto_wr` pulse loads all automatic-service bits from `auto_wdata` (bit i for source i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | NSRC | Per-source request flag |
| src_en | input | NSRC | Per-source enable |
| src_lvl | input | 3*NSRC | Source levels, source i in bits [3i+2:3i] |
| auto_wr | input | 1 | Load strobe for the automatic-service bits |
| auto_wdata | input | NSRC | New automatic-service bits |
| insn_bound | input | 1 | Instruction boundary, acceptance point |
| str_step | input | 1 | String-operation step completed, acceptance point |
| sw_int | input | 1 | Software interrupt instruction |
| reti | input | 1 | Return-from-interrupt restore strobe |
| rest_ilm | input | 3 | Restored mask |
| rest_gie | input | 1 | Restored global enable |
| rest_stk | input | 1 | Restored stack flag |
| cpu_wr | input | 1 | Direct load of mask and flags |
| cpu_ilm | input | 3 | Mask value to load |
| cpu_gie | input | 1 | Global enable to load |
| cpu_stk | input | 1 | Stack flag to load |
| save_done | input | 1 | CPU finished saving registers |
| xfer_count | input | CNT_W | Transfer count taken when a run starts |
| xfer_done | input | 1 | One transfer completed |
| xfer_term | input | 1 | Source asks to end the run |
| accept | output | 1 | Hardware interrupt accepted (one cycle) |
| vec_num | output | 8 | Vector number, valid with `accept` |
| save_req | output | 1 | Request to save dedicated registers |
| mask_upd | output | 1 | Mask and stack flag being updated |
| vec_load | output | 1 | CPU should load bank and program counter from the vector |
| ilm | output | 3 | Current level mask |
| gie | output | 1 | Global interrupt enable |
| sys_stk | output | 1 | Stack flag, 1 selects the system stack |
| xfer_req | output | 1 | Transfer run active |
| xfer_src | output | IDX_W | Source served by the run |
| busy | output | 1 | Sequence or transfer run in progress |

## Verification
The assertions take for granted that the CPU sends `sw_int`, `reti` and `cpu_wr` only while `busy` is low. They also take for granted that these three never arrive in the same cycle, and that `save_done` comes only while `save_req` is high. They further assume that `xfer_done` and `xfer_term` pulse only while `xfer_req` is high. The bench drives each of these strobes for a single cycle from tasks that first wait for the block to go idle, or that wait for the matching request output. The random trials clear all automatic-service bits, so every trial that is accepted runs the normal save-update-vector path to completion before the next trial starts.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

  localparam int unsigned LVL_W = 3;
  localparam int unsigned VEC_W = 8;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SAVE   = 2'd1,
    SQ_UPDATE = 2'd2,
    SQ_VECTOR = 2'd3
  } seq_state_e;

  // Gating rule for one source: all enables set and level strictly below mask.
  function automatic logic lvl_admits(input logic g, input logic r, input logic e,
                                      input logic [LVL_W-1:0] l,
                                      input logic [LVL_W-1:0] m);
    return g & r & e & (l < m);
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] base,
                                              input logic [VEC_W-1:0] idx);
    return base + idx;
  endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_dispatch_pkg::*;
#(
  parameter int unsigned NSRC  = 8,
  parameter int unsigned IDX_W = 3
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  gie,
  input  logic [LVL_W-1:0]      ilm,
  input  logic [NSRC-1:0]       req,
  input  logic [NSRC-1:0]       en,
  input  logic [NSRC*LVL_W-1:0] lvl,
  output logic                  hit,
  output logic [IDX_W-1:0]      win_idx,
  output logic [LVL_W-1:0]      win_lvl
);

  logic [NSRC-1:0] qual;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_qual
      assign qual[g] = lvl_admits(gie, req[g], en[g], lvl[g*LVL_W +: LVL_W], ilm);
    end
  endgenerate

  // Linear scan: strict compare keeps the lower index on equal levels.
  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    win_lvl = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (qual[i] && (!hit || (lvl[i*LVL_W +: LVL_W] < win_lvl))) begin
        hit     = 1'b1;
        win_idx = IDX_W'(i);
        win_lvl = lvl[i*LVL_W +: LVL_W];
      end
    end
  end

  p_win_below_mask_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> (gie && (win_lvl < ilm)));

endmodule

// File: rtl/irq_xfer.sv
module irq_xfer
  import irq_dispatch_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned IDX_W = 3
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IDX_W-1:0] start_idx,
  input  logic [LVL_W-1:0] start_lvl,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic             done,
  input  logic             term,
  output logic             act,
  output logic [IDX_W-1:0] idx,
  output logic [LVL_W-1:0] lvl,
  output logic             finish
);

  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);
  assign finish   = act & (term | cnt_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      act <= 1'b0;
      cnt <= '0;
      idx <= '0;
      lvl <= '0;
    end else if (start) begin
      act <= 1'b1;
      cnt <= start_cnt;
      idx <= start_idx;
      lvl <= start_lvl;
    end else if (finish) begin
      act <= 1'b0;
    end else if (act && done && !cnt_zero) begin
      cnt <= cnt - 1'b1;
    end
  end

  p_cnt_dec_r7: assert property (@(posedge clk) disable iff (rst)
    (act && done && !cnt_zero && !term) |=> (cnt == $past(cnt) - 1'b1));

  p_run_ends_r8: assert property (@(posedge clk) disable iff (rst)
    (act && term && !start) |=> !act);

endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_dispatch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hw_go,
  input  logic sw_go,
  input  logic save_done,
  output logic idle,
  output logic accept,
  output logic save_req,
  output logic mask_upd,
  output logic vec_load
);

  seq_state_e state;
  logic       sw_path;

  assign idle     = (state == SQ_IDLE);
  assign save_req = (state == SQ_SAVE);
  assign mask_upd = (state == SQ_UPDATE);
  assign vec_load = (state == SQ_VECTOR);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      sw_path <= 1'b0;
      accept  <= 1'b0;
    end else begin
      accept <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (sw_go) begin
            state   <= SQ_SAVE;
            sw_path <= 1'b1;
          end else if (hw_go) begin
            state   <= SQ_SAVE;
            sw_path <= 1'b0;
            accept  <= 1'b1;
          end
        end
        SQ_SAVE: begin
          if (save_done) state <= sw_path ? SQ_IDLE : SQ_UPDATE;
        end
        SQ_UPDATE: state <= SQ_VECTOR;
        SQ_VECTOR: state <= SQ_IDLE;
        default:   state <= SQ_IDLE;
      endcase
    end
  end

  p_one_phase_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({save_req, mask_upd, vec_load}));

  p_accept_with_save_r5: assert property (@(posedge clk) disable iff (rst)
    accept |-> save_req);

  p_save_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (save_req && !save_done) |=> save_req);

  p_update_then_vector_r5: assert property (@(posedge clk) disable iff (rst)
    mask_upd |=> vec_load);

endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_dispatch_pkg::*;
#(
  parameter int unsigned      NSRC     = 8,
  parameter int unsigned      CNT_W    = 16,
  parameter logic [VEC_W-1:0] VEC_BASE = VEC_W'(16),
  localparam int unsigned     IDX_W    = (NSRC > 1) ? $clog2(NSRC) : 1
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NSRC-1:0]       src_req,
  input  logic [NSRC-1:0]       src_en,
  input  logic [NSRC*LVL_W-1:0] src_lvl,
  input  logic                  auto_wr,
  input  logic [NSRC-1:0]       auto_wdata,
  input  logic                  insn_bound,
  input  logic                  str_step,
  input  logic                  sw_int,
  input  logic                  reti,
  input  logic [LVL_W-1:0]      rest_ilm,
  input  logic                  rest_gie,
  input  logic                  rest_stk,
  input  logic                  cpu_wr,
  input  logic [LVL_W-1:0]      cpu_ilm,
  input  logic                  cpu_gie,
  input  logic                  cpu_stk,
  input  logic                  save_done,
  input  logic [CNT_W-1:0]      xfer_count,
  input  logic                  xfer_done,
  input  logic                  xfer_term,
  output logic                  accept,
  output logic [VEC_W-1:0]      vec_num,
  output logic                  save_req,
  output logic                  mask_upd,
  output logic                  vec_load,
  output logic [LVL_W-1:0]      ilm,
  output logic                  gie,
  output logic                  sys_stk,
  output logic                  xfer_req,
  output logic [IDX_W-1:0]      xfer_src,
  output logic                  busy
);

  logic             hit;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic             chk_pt, seq_idle, take_ok;
  logic             sw_take, hw_take, xf_start, xf_finish, hw_go;
  logic             xf_act;
  logic [IDX_W-1:0] xf_idx;
  logic [LVL_W-1:0] xf_lvl;
  logic [NSRC-1:0]  auto_en_q;
  logic [IDX_W-1:0] cap_idx;
  logic [LVL_W-1:0] cap_lvl;
  logic [LVL_W-1:0] ilm_q;
  logic             gie_q, stk_q;

  irq_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst(rst), .gie(gie_q), .ilm(ilm_q),
    .req(src_req), .en(src_en), .lvl(src_lvl),
    .hit(hit), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  // Named decision events.
  assign chk_pt   = insn_bound | str_step;
  assign take_ok  = seq_idle & ~xf_act;
  assign sw_take  = take_ok & sw_int;
  assign hw_take  = take_ok & ~sw_int & chk_pt & hit & ~auto_en_q[win_idx];
  assign xf_start = take_ok & ~sw_int & chk_pt & hit &  auto_en_q[win_idx];
  assign hw_go    = hw_take | xf_finish;

  irq_xfer #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_xfer (
    .clk(clk), .rst(rst), .start(xf_start),
    .start_idx(win_idx), .start_lvl(win_lvl), .start_cnt(xfer_count),
    .done(xfer_done), .term(xfer_term),
    .act(xf_act), .idx(xf_idx), .lvl(xf_lvl), .finish(xf_finish)
  );

  irq_seq u_seq (
    .clk(clk), .rst(rst), .hw_go(hw_go), .sw_go(sw_take),
    .save_done(save_done), .idle(seq_idle), .accept(accept),
    .save_req(save_req), .mask_upd(mask_upd), .vec_load(vec_load)
  );

  // Captured request for the running sequence.
  always_ff @(posedge clk) begin
    if (rst) begin
      cap_idx <= '0;
      cap_lvl <= '0;
    end else if (hw_take) begin
      cap_idx <= win_idx;
      cap_lvl <= win_lvl;
    end else if (xf_finish) begin
      cap_idx <= xf_idx;
      cap_lvl <= xf_lvl;
    end
  end

  // Automatic-service bits: a finished run clears its source.
  always_ff @(posedge clk) begin
    if (rst) begin
      auto_en_q <= '0;
    end else begin
      if (auto_wr)   auto_en_q          <= auto_wdata;
      if (xf_finish) auto_en_q[xf_idx]  <= 1'b0;
    end
  end

  // Mask, global enable and stack flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      ilm_q <= '1;
      gie_q <= 1'b0;
      stk_q <= 1'b0;
    end else if (mask_upd) begin
      ilm_q <= cap_lvl;
      stk_q <= 1'b1;
    end else if (sw_take) begin
      gie_q <= 1'b0;
    end else if (reti) begin
      ilm_q <= rest_ilm;
      gie_q <= rest_gie;
      stk_q <= rest_stk;
    end else if (cpu_wr) begin
      ilm_q <= cpu_ilm;
      gie_q <= cpu_gie;
      stk_q <= cpu_stk;
    end
  end

  assign vec_num  = accept ? vec_of(VEC_BASE, VEC_W'(cap_idx)) : '0;
  assign ilm      = ilm_q;
  assign gie      = gie_q;
  assign sys_stk  = stk_q;
  assign xfer_req = xf_act;
  assign xfer_src = xf_idx;
  assign busy     = ~seq_idle | xf_act;

  p_sw_clears_gie_r9: assert property (@(posedge clk) disable iff (rst)
    sw_take |=> (!gie && save_req && !accept));

  p_hw_mask_r6: assert property (@(posedge clk) disable iff (rst)
    mask_upd |=> ((ilm == $past(cap_lvl)) && sys_stk));

  p_no_accept_in_run_r7: assert property (@(posedge clk) disable iff (rst)
    xfer_req |-> !accept);

  p_level_seven_never_r2: assert property (@(posedge clk) disable iff (rst)
    accept |-> (cap_lvl != '1));

  p_run_clears_auto_r7: assert property (@(posedge clk) disable iff (rst)
    (xf_finish && !auto_wr) |=> (!auto_en_q[$past(xf_idx)] && accept));

endmodule

// File: tb/sim_irq_dispatch_ctrl.sv
module sim_irq_dispatch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int VB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_req = '0, src_en = '0, auto_wdata = '0;
  logic [N*3-1:0] src_lvl = '0;
  logic auto_wr = 0, insn_bound = 0, str_step = 0, sw_int = 0, reti = 0;
  logic [2:0] rest_ilm = 0, cpu_ilm = 0;
  logic rest_gie = 0, rest_stk = 0, cpu_wr = 0, cpu_gie = 0, cpu_stk = 0;
  logic save_done = 0, xfer_done = 0, xfer_term = 0;
  logic [15:0] xfer_count = 0;
  logic accept, save_req, mask_upd, vec_load, gie, sys_stk, xfer_req, busy;
  logic [7:0] vec_num;
  logic [2:0] ilm, xfer_src;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_dispatch_ctrl u0 (
    .clk(clk), .rst(rst), .src_req(src_req), .src_en(src_en), .src_lvl(src_lvl),
    .auto_wr(auto_wr), .auto_wdata(auto_wdata), .insn_bound(insn_bound),
    .str_step(str_step), .sw_int(sw_int), .reti(reti), .rest_ilm(rest_ilm),
    .rest_gie(rest_gie), .rest_stk(rest_stk), .cpu_wr(cpu_wr), .cpu_ilm(cpu_ilm),
    .cpu_gie(cpu_gie), .cpu_stk(cpu_stk), .save_done(save_done),
    .xfer_count(xfer_count), .xfer_done(xfer_done), .xfer_term(xfer_term),
    .accept(accept), .vec_num(vec_num), .save_req(save_req), .mask_upd(mask_upd),
    .vec_load(vec_load), .ilm(ilm), .gie(gie), .sys_stk(sys_stk),
    .xfer_req(xfer_req), .xfer_src(xfer_src), .busy(busy)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Reference pick: search levels upward, then indices upward.
  task automatic ref_pick(input logic g, input logic [2:0] m, output bit any,
                          output int idx, output int lv);
    any = 0; idx = 0; lv = 7;
    for (int L = 0; L < 7; L++) begin
      if (!any && g && (L < m)) begin
        for (int i = 0; i < N; i++) begin
          if (!any && src_req[i] && src_en[i] && (src_lvl[i*3 +: 3] == L)) begin
            any = 1; idx = i; lv = L;
          end
        end
      end
    end
  endtask

  task automatic set_src(input int i, input int lv);
    src_req[i] = 1'b1;
    src_en[i]  = 1'b1;
    src_lvl[i*3 +: 3] = 3'(lv);
  endtask

  task automatic cpu_load(input int m, input bit g, input bit s);
    cpu_ilm = 3'(m); cpu_gie = g; cpu_stk = s; cpu_wr = 1;
    tick();
    cpu_wr = 0;
  endtask

  task automatic boundary();
    insn_bound = 1;
    tick();
    insn_bound = 0;
  endtask

  // Called in the accept cycle; drives the rest of the normal path.
  task automatic run_hw(input int idx, input int lv, input string rq);
    int w;
    chk({rq, " accept"}, accept, 1);
    chk({rq, " vec_num"}, vec_num, VB + idx);
    chk("R5 save_req with accept", save_req, 1);
    w = $urandom_range(0, 3);
    for (int k = 0; k < w; k++) begin
      tick();
      chk("R5 save_req held", save_req, 1);
      chk("R4 accept one cycle", accept, 0);
      chk("R4 vec_num idle", vec_num, 0);
    end
    save_done = 1;
    tick();
    save_done = 0;
    chk("R5 mask_upd", mask_upd, 1);
    tick();
    chk("R5 vec_load", vec_load, 1);
    chk("R6 ilm", ilm, lv);
    chk("R6 sys_stk", sys_stk, 1);
    tick();
    chk("R5 idle after vector", busy, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    bit any; int ei, el; bit g0;
    void'($urandom(32'd20240611));
    repeat (3) tick();
    chk("R1 ilm", ilm, 7);
    chk("R1 gie", gie, 0);
    chk("R1 sys_stk", sys_stk, 0);
    chk("R1 busy", busy, 0);
    chk("R1 accept", accept, 0);
    rst = 0;
    tick();

    // R11: direct load
    cpu_load(4, 1, 0);
    chk("R11 ilm", ilm, 4);
    chk("R11 gie", gie, 1);

    // R2: equal level refused, disabled source refused, gie off refused
    set_src(0, 4);
    boundary();
    chk("R2 level equal to mask", accept, 0);
    src_req = '0; src_en = '0;
    set_src(0, 3); src_en[0] = 0;
    boundary();
    chk("R2 source disabled", accept, 0);
    src_en[0] = 1;
    cpu_load(4, 0, 0);
    boundary();
    chk("R2 global enable off", accept, 0);
    cpu_load(7, 1, 0);
    src_req = '0; src_en = '0;
    set_src(1, 7);
    boundary();
    chk("R2 level seven", accept, 0);

    // R3: only at boundary or string step
    src_req = '0; src_en = '0;
    cpu_load(4, 1, 0);
    set_src(2, 1);
    repeat (3) tick();
    chk("R3 no check point", accept, 0);
    chk("R3 no check point busy", busy, 0);
    str_step = 1;
    tick();
    str_step = 0;
    run_hw(2, 1, "R3 string step");

    // R4 tie + R5 blocking
    src_req = '0; src_en = '0;
    cpu_load(7, 1, 0);
    set_src(5, 2); set_src(3, 2); set_src(6, 4);
    boundary();
    chk("R4 tie accept", accept, 1);
    chk("R4 tie lowest index", vec_num, VB + 3);
    src_req = '0; src_en = '0;
    set_src(0, 0);
    insn_bound = 1;
    tick();
    chk("R5 blocked while saving", accept, 0);
    tick();
    insn_bound = 0;
    chk("R5 still blocked", accept, 0);
    save_done = 1; tick(); save_done = 0;
    chk("R5 mask_upd after block", mask_upd, 1);
    tick();
    chk("R6 ilm after tie", ilm, 2);
    tick();
    src_req = '0; src_en = '0;

    // R9: software interrupt ignores gating
    cpu_load(0, 1, 0);
    sw_int = 1;
    tick();
    sw_int = 0;
    chk("R9 gie cleared", gie, 0);
    chk("R9 save_req", save_req, 1);
    chk("R9 no accept", accept, 0);
    save_done = 1; tick(); save_done = 0;
    chk("R9 idle after save", busy, 0);
    chk("R9 mask unchanged", ilm, 0);
    cpu_load(0, 0, 0);
    sw_int = 1; tick(); sw_int = 0;
    chk("R9 taken with gie off", save_req, 1);
    save_done = 1; tick(); save_done = 0;

    // R10: return restores
    rest_ilm = 5; rest_gie = 1; rest_stk = 0; reti = 1;
    tick();
    reti = 0;
    chk("R10 ilm", ilm, 5);
    chk("R10 gie", gie, 1);
    chk("R10 stk", sys_stk, 0);

    // R7: automatic service, count 3
    cpu_load(7, 1, 0);
    auto_wdata = 8'b0000_0010; auto_wr = 1; tick(); auto_wr = 0;
    set_src(1, 3);
    xfer_count = 3;
    boundary();
    chk("R7 xfer_req", xfer_req, 1);
    chk("R7 xfer_src", xfer_src, 1);
    chk("R7 no accept", accept, 0);
    xfer_done = 1;
    tick(); tick();
    chk("R7 run continues", xfer_req, 1);
    tick();
    xfer_done = 0;
    chk("R7 run at zero", xfer_req, 1);
    chk("R7 no accept yet", accept, 0);
    tick();
    chk("R7 run ended", xfer_req, 0);
    run_hw(1, 3, "R7 after run");
    cpu_load(7, 1, 0);
    boundary();
    chk("R7 auto bit cleared", xfer_req, 0);
    run_hw(1, 3, "R7 direct path");
    src_req = '0; src_en = '0;

    // R8: termination
    cpu_load(7, 1, 0);
    auto_wdata = 8'b0001_0000; auto_wr = 1; tick(); auto_wr = 0;
    set_src(4, 0);
    xfer_count = 100;
    boundary();
    chk("R8 xfer_req", xfer_req, 1);
    xfer_done = 1; tick(); xfer_done = 0;
    xfer_term = 1; tick(); xfer_term = 0;
    chk("R8 run ended", xfer_req, 0);
    run_hw(4, 0, "R8 after term");
    src_req = '0; src_en = '0;

    // R7: count zero
    cpu_load(7, 1, 0);
    auto_wdata = 8'b0100_0000; auto_wr = 1; tick(); auto_wr = 0;
    set_src(6, 5);
    xfer_count = 0;
    boundary();
    chk("R7 zero count starts", xfer_req, 1);
    chk("R7 zero xfer_src", xfer_src, 6);
    tick();
    chk("R7 zero count ends", xfer_req, 0);
    run_hw(6, 5, "R7 zero count");
    src_req = '0; src_en = '0;

    // Random trials (R2, R4, R6)
    auto_wdata = '0; auto_wr = 1; tick(); auto_wr = 0;
    for (int t = 0; t < 150; t++) begin
      g0 = ($urandom_range(0, 7) != 0);
      cpu_load($urandom_range(0, 7), g0, 0);
      src_req = N'($urandom);
      src_en  = N'($urandom) | N'($urandom);
      src_lvl = (N*3)'($urandom);
      ref_pick(gie, ilm, any, ei, el);
      if ($urandom_range(0, 1) == 1) insn_bound = 1; else str_step = 1;
      tick();
      insn_bound = 0; str_step = 0;
      if (any) run_hw(ei, el, "R4 random");
      else begin
        chk("R2 random refuse", accept, 0);
        chk("R2 random idle", busy, 0);
      end
      src_req = '0;
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule